// File: doc/BRIEF.md
# Dual-Port Video Memory Transfer Controller

This block is a synthesizable model of a dual-port video memory. It has a small random-access array of rows and a serial register that is exactly one row wide. A serial port shifts words in or out of that register, one word for each serial clock rising edge. Whole rows move between the array and the serial register through transfer cycles. Each transfer cycle is framed by an active-low row strobe, and its type is set by the other strobes at the moment the row strobe falls.

Three transfer types exist:
- A read transfer copies an array row into the serial register and turns the port to output.
- A write transfer commits the serial register into an array row.
- A pseudo write transfer moves no data. It only turns the port to input, so that new words can be shifted in after a read transfer.

The column address captured during the cycle sets where the serial pointer starts. The block enforces the following rules and reports each violation on a single error output:
- The serial clock is locked out while a write-type cycle is in progress and for a fixed time after it.
- Read transfers must be spaced apart.
- Every transfer cycle must toggle the column strobe.
- A write transfer is not allowed while the port is in output mode.

A plain row-load port fills the array from the host.

All inputs are sampled on the block clock. A strobe edge is acted on two clock edges after the input changes, and a committed transfer takes effect one edge after that.

Top module: `vram_xfer_ctrl`

## Requirements
- R1: After reset the serial port is in input mode (`sport_in`=1), `err` is 0 and `sdout` is 0.
- R2: A write transfer copies the whole serial register into the array row whose address was on `addr` when `rs_n` fell. A write transfer is a row-strobe fall with `te_n`=0, `we_n`=0 and `se_n`=0.
- R3: A pseudo write transfer is a row-strobe fall with `te_n`=0, `we_n`=0 and `se_n`=1. It sets `sport_in`=1, reports no error, and changes neither the array nor the serial register.
- R4: The column address on `addr` at the first `cs_n` fall of a transfer sets the serial pointer. The pointer advances by one on each accepted serial edge and wraps from column COLS-1 to column 0.
- R5: A read transfer is a row-strobe fall with `te_n`=0 and `we_n`=1. It loads the addressed row into the serial register and sets `sport_in`=0. Each accepted `sclk` rising edge then places the word at the pointer on `sdout`.
- R6: In input mode, each accepted `sclk` rising edge stores `sdin` at the pointer. The stored words reach the array only when a later write transfer commits them.
- R7: An `sclk` rising edge is refused and raises `err` in two windows: while the row strobe of a write or pseudo write transfer is low, and for LOCK_CYC clocks after such a transfer completes. A refused edge neither stores a word nor moves the pointer.
- R8: A transfer in which `cs_n` never falls while `rs_n` is low raises `err` and has no effect.
- R9: A write transfer attempted while the port is in output mode raises `err`. It leaves the array unchanged and the port in output mode.
- R10: A read transfer whose row strobe falls within RD_GAP_CYC clocks of the first accepted serial edge after the previous read transfer raises `err` and is dropped.
- R11: A row-strobe cycle with `te_n`=1 at the fall is ignored. It raises no error and changes neither the port mode nor the serial register.
- R12: A high `ld_en` writes `ld_data` into row `ld_row`. If a write transfer commits in the same clock, the load is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| rs_n | input | 1 | Row strobe, active low; its fall starts a cycle |
| cs_n | input | 1 | Column strobe, active low; its fall captures the column |
| we_n | input | 1 | Write enable, active low |
| te_n | input | 1 | Transfer enable, active low |
| se_n | input | 1 | Serial enable, active low |
| addr | input | AW | Row address at the row-strobe fall, column at the column-strobe fall |
| sclk | input | 1 | Serial clock; rising edges shift words |
| sdin | input | DW | Serial input word |
| sdout | output | DW | Serial output word |
| sport_in | output | 1 | 1 when the serial port is in input mode |
| err | output | 1 | One-clock pulse on any rule violation |
| ld_en | input | 1 | Row-load strobe |
| ld_row | input | RW | Row to load |
| ld_data | input | COLS*DW | Row contents to load, column 0 in the low bits |

## Verification
Two functions can fall in the same clock: a write transfer commit and a host row load, because both need the array's single write port. The bench provokes this by raising `ld_en` for a different row exactly in the clock where the write commit lands, two clocks after it drives `rs_n` high. It then judges the result by read transfers: the load target row must still hold its old pattern, and the transfer target row must hold the shifted-in words. A second overlap is a serial edge that lands in the same clock as the row-strobe rise of a pseudo transfer; this edge must be refused and flagged.

// File: rtl/vram_pkg.sv
package vram_pkg;
  typedef enum logic [1:0] {
    XK_NONE   = 2'd0,
    XK_READ   = 2'd1,
    XK_WRITE  = 2'd2,
    XK_PSEUDO = 2'd3
  } xfer_kind_e;
endpackage

// File: rtl/vram_strobe_sync.sv
module vram_strobe_sync #(
  parameter int          W    = 1,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cur  <= INIT;
      prev <= INIT;
    end else begin
      cur  <= din;
      prev <= cur;
    end
  end
endmodule

// File: rtl/vram_xfer_decode.sv
module vram_xfer_decode
  import vram_pkg::*;
#(
  parameter int RW = 3,
  parameter int CW = 3,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rs_fall,
  input  logic          rs_rise,
  input  logic          cs_fall,
  input  logic          te_n,
  input  logic          we_n,
  input  logic          se_n,
  input  logic [AW-1:0] addr,
  input  logic          gap_busy,
  output logic          go,
  output xfer_kind_e    go_kind,
  output logic [RW-1:0] row_cap,
  output logic [CW-1:0] col_cap,
  output logic          busy_wr,
  output logic          err_cas,
  output logic          err_gap
);
  logic       in_cyc, cs_seen, abort;
  xfer_kind_e cyc_kind;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_cyc   <= 1'b0;
      cs_seen  <= 1'b0;
      abort    <= 1'b0;
      cyc_kind <= XK_NONE;
      row_cap  <= '0;
      col_cap  <= '0;
      go       <= 1'b0;
      go_kind  <= XK_NONE;
      busy_wr  <= 1'b0;
      err_cas  <= 1'b0;
      err_gap  <= 1'b0;
    end else begin
      go      <= 1'b0;
      err_cas <= 1'b0;
      err_gap <= 1'b0;
      if (rs_fall && !te_n) begin
        in_cyc  <= 1'b1;
        cs_seen <= 1'b0;
        row_cap <= addr[RW-1:0];
        if (we_n) begin
          cyc_kind <= XK_READ;
          abort    <= gap_busy;
          err_gap  <= gap_busy;
          busy_wr  <= 1'b0;
        end else begin
          cyc_kind <= se_n ? XK_PSEUDO : XK_WRITE;
          abort    <= 1'b0;
          busy_wr  <= 1'b1;
        end
      end
      if (cs_fall && (in_cyc || (rs_fall && !te_n))) begin
        cs_seen <= 1'b1;
        col_cap <= addr[CW-1:0];
      end
      if (in_cyc && rs_rise) begin
        in_cyc  <= 1'b0;
        busy_wr <= 1'b0;
        if (!cs_seen) begin
          err_cas <= 1'b1;
        end else if (!abort) begin
          go      <= 1'b1;
          go_kind <= cyc_kind;
        end
      end
    end
  end

  // R8
  no_cas_err_chk: assert property (@(posedge clk) disable iff (rst)
    (in_cyc && rs_rise && !cs_seen) |=> (err_cas && !go));
endmodule

// File: rtl/vram_serial_reg.sv
module vram_serial_reg
  import vram_pkg::*;
#(
  parameter int COLS     = 8,
  parameter int DW       = 8,
  parameter int LOCK_CYC = 4,
  parameter int GAP_CYC  = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sclk_rise,
  input  logic [DW-1:0]      sdin,
  input  logic               go,
  input  xfer_kind_e         go_kind,
  input  logic [$clog2(COLS)-1:0] go_col,
  input  logic               busy_wr,
  input  logic [COLS*DW-1:0] row_data,
  output logic [DW-1:0]      sdout,
  output logic               dir_in,
  output logic [COLS*DW-1:0] sam_flat,
  output logic               gap_busy,
  output logic               wr_ok,
  output logic               err_lock,
  output logic               err_wrdir
);
  localparam int CW = $clog2(COLS);
  localparam int LW = $clog2(LOCK_CYC + 1);
  localparam int GW = $clog2(GAP_CYC + 1);

  logic [DW-1:0] sam [COLS];
  logic [CW-1:0] ptr;
  logic [LW-1:0] lock_cnt;
  logic [GW-1:0] gap_cnt;
  logic          rd_pend;
  logic          locked, acc;

  assign locked   = busy_wr | go | (lock_cnt != '0);
  assign acc      = sclk_rise & ~locked;
  assign gap_busy = (gap_cnt != '0);
  assign wr_ok    = go && (go_kind == XK_WRITE) && dir_in;

  always_comb begin
    for (int c = 0; c < COLS; c++) sam_flat[c*DW +: DW] = sam[c];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < COLS; c++) sam[c] <= '0;
      ptr       <= '0;
      dir_in    <= 1'b1;
      lock_cnt  <= '0;
      gap_cnt   <= '0;
      rd_pend   <= 1'b0;
      sdout     <= '0;
      err_lock  <= 1'b0;
      err_wrdir <= 1'b0;
    end else begin
      err_lock  <= sclk_rise & locked;
      err_wrdir <= go && (go_kind == XK_WRITE) && !dir_in;
      if (lock_cnt != '0) lock_cnt <= lock_cnt - 1'b1;
      if (gap_cnt != '0)  gap_cnt  <= gap_cnt - 1'b1;
      if (go) begin
        case (go_kind)
          XK_READ: begin
            for (int c = 0; c < COLS; c++) sam[c] <= row_data[c*DW +: DW];
            dir_in  <= 1'b0;
            ptr     <= go_col;
            rd_pend <= 1'b1;
          end
          XK_PSEUDO: begin
            dir_in   <= 1'b1;
            ptr      <= go_col;
            rd_pend  <= 1'b0;
            lock_cnt <= LW'(LOCK_CYC);
          end
          XK_WRITE: begin
            if (dir_in) begin
              ptr      <= go_col;
              rd_pend  <= 1'b0;
              lock_cnt <= LW'(LOCK_CYC);
            end
          end
          default: ;
        endcase
      end else if (acc) begin
        ptr <= (ptr == CW'(COLS - 1)) ? '0 : ptr + 1'b1;
        if (dir_in) sam[ptr] <= sdin;
        else        sdout    <= sam[ptr];
        if (rd_pend) begin
          gap_cnt <= GW'(GAP_CYC);
          rd_pend <= 1'b0;
        end
      end
    end
  end

  // R3
  pseudo_dir_chk: assert property (@(posedge clk) disable iff (rst)
    (go && go_kind == XK_PSEUDO) |=> dir_in);
  // R5
  read_dir_chk: assert property (@(posedge clk) disable iff (rst)
    (go && go_kind == XK_READ) |=> !dir_in);
  // R7
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sclk_rise && lock_cnt != '0 && !go) |=> ($stable(ptr) && err_lock));
  // R9
  wr_dir_chk: assert property (@(posedge clk) disable iff (rst)
    (go && go_kind == XK_WRITE && !dir_in) |=> (!dir_in && err_wrdir));
endmodule

// File: rtl/vram_row_array.sv
module vram_row_array #(
  parameter int ROWS  = 8,
  parameter int WIDTH = 64
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [$clog2(ROWS)-1:0] waddr,
  input  logic [WIDTH-1:0]        wdata,
  input  logic [$clog2(ROWS)-1:0] raddr,
  output logic [WIDTH-1:0]        rdata
);
  logic [WIDTH-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/vram_xfer_ctrl.sv
module vram_xfer_ctrl
  import vram_pkg::*;
#(
  parameter int ROWS      = 8,
  parameter int COLS      = 8,
  parameter int DW        = 8,
  parameter int LOCK_CYC  = 4,
  parameter int CLK_NS    = 10,
  parameter int RD_GAP_NS = 30,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(COLS),
  localparam int AW = (RW > CW) ? RW : CW,
  localparam int SW = COLS * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rs_n,
  input  logic          cs_n,
  input  logic          we_n,
  input  logic          te_n,
  input  logic          se_n,
  input  logic [AW-1:0] addr,
  input  logic          sclk,
  input  logic [DW-1:0] sdin,
  output logic [DW-1:0] sdout,
  output logic          sport_in,
  output logic          err,
  input  logic          ld_en,
  input  logic [RW-1:0] ld_row,
  input  logic [SW-1:0] ld_data
);
  localparam int RD_GAP_CYC = (RD_GAP_NS + CLK_NS - 1) / CLK_NS;

  logic [5:0]    stb_cur, stb_prev;
  logic [AW-1:0] addr_q;
  logic          rs_fall, rs_rise, cs_fall, sclk_rise;
  logic          go, busy_wr, err_cas, err_gap, err_lock, err_wrdir;
  logic          gap_busy, wr_ok;
  xfer_kind_e    go_kind;
  logic [RW-1:0] row_cap;
  logic [CW-1:0] col_cap;
  logic [SW-1:0] sam_flat, ram_q;

  vram_strobe_sync #(.W(6), .INIT(6'b011111)) stb_i (
    .clk(clk), .rst(rst),
    .din({sclk, se_n, te_n, we_n, cs_n, rs_n}),
    .cur(stb_cur), .prev(stb_prev)
  );

  always_ff @(posedge clk) begin
    if (rst) addr_q <= '0;
    else     addr_q <= addr;
  end

  assign rs_fall   =  stb_prev[0] & ~stb_cur[0];
  assign rs_rise   = ~stb_prev[0] &  stb_cur[0];
  assign cs_fall   =  stb_prev[1] & ~stb_cur[1];
  assign sclk_rise = ~stb_prev[5] &  stb_cur[5];

  vram_xfer_decode #(.RW(RW), .CW(CW), .AW(AW)) dec_i (
    .clk(clk), .rst(rst),
    .rs_fall(rs_fall), .rs_rise(rs_rise), .cs_fall(cs_fall),
    .te_n(stb_cur[3]), .we_n(stb_cur[2]), .se_n(stb_cur[4]),
    .addr(addr_q), .gap_busy(gap_busy),
    .go(go), .go_kind(go_kind), .row_cap(row_cap), .col_cap(col_cap),
    .busy_wr(busy_wr), .err_cas(err_cas), .err_gap(err_gap)
  );

  vram_serial_reg #(.COLS(COLS), .DW(DW), .LOCK_CYC(LOCK_CYC), .GAP_CYC(RD_GAP_CYC)) ser_i (
    .clk(clk), .rst(rst),
    .sclk_rise(sclk_rise), .sdin(sdin),
    .go(go), .go_kind(go_kind), .go_col(col_cap), .busy_wr(busy_wr),
    .row_data(ram_q),
    .sdout(sdout), .dir_in(sport_in), .sam_flat(sam_flat),
    .gap_busy(gap_busy), .wr_ok(wr_ok),
    .err_lock(err_lock), .err_wrdir(err_wrdir)
  );

  vram_row_array #(.ROWS(ROWS), .WIDTH(SW)) ram_i (
    .clk(clk),
    .we(wr_ok | ld_en),
    .waddr(wr_ok ? row_cap : ld_row),
    .wdata(wr_ok ? sam_flat : ld_data),
    .raddr(row_cap),
    .rdata(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) err <= 1'b0;
    else     err <= err_cas | err_gap | err_lock | err_wrdir;
  end

  // R10
  gap_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (rs_fall && !stb_cur[3] && stb_cur[2] && gap_busy) |=> err_gap);
endmodule

// File: tb/vram_xfer_ctrl_tb_top.sv
module vram_xfer_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LOCK = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rs_n = 1'b1, cs_n = 1'b1, we_n = 1'b1, te_n = 1'b1, se_n = 1'b1;
  logic [2:0]  addr = '0;
  logic        sclk = 1'b0;
  logic [7:0]  sdin = '0;
  logic [7:0]  sdout;
  logic        sport_in, err;
  logic        ld_en = 1'b0;
  logic [2:0]  ld_row = '0;
  logic [63:0] ld_data = '0;

  int total = 0;
  int bad = 0;
  int nerr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vram_xfer_ctrl dut_i (
    .clk(clk), .rst(rst), .rs_n(rs_n), .cs_n(cs_n), .we_n(we_n),
    .te_n(te_n), .se_n(se_n), .addr(addr), .sclk(sclk), .sdin(sdin),
    .sdout(sdout), .sport_in(sport_in), .err(err),
    .ld_en(ld_en), .ld_row(ld_row), .ld_data(ld_data)
  );

  always @(negedge clk) if (err === 1'b1) nerr++;

  function automatic logic [7:0] pat(input int r, input int c);
    return 8'(r * 16 + c + 1);
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // rd=1 read transfer; otherwise se selects pseudo (1) or write (0)
  task automatic xfer(input bit rd, input bit se, input int row, input int col,
                      input bit tog, input int post);
    te_n = 1'b0; we_n = rd; se_n = rd ? 1'b1 : se; addr = 3'(row);
    rs_n = 1'b0;
    tick(2);
    addr = 3'(col);
    if (tog) cs_n = 1'b0;
    tick(2);
    rs_n = 1'b1; cs_n = 1'b1; te_n = 1'b1; we_n = 1'b1; se_n = 1'b1;
    tick(post);
  endtask

  task automatic spulse(input logic [7:0] d, output logic [7:0] q);
    sdin = d; sclk = 1'b1;
    tick(1);
    sclk = 1'b0;
    tick(1);
    q = sdout;
  endtask

  task automatic t_reset();
    tick(3);
    chk("R1 sport_in", int'(sport_in), 1);
    chk("R1 err", int'(err), 0);
    chk("R1 sdout", int'(sdout), 0);
  endtask

  task automatic t_load();
    for (int r = 0; r < 8; r++) begin
      ld_en = 1'b1; ld_row = 3'(r);
      for (int c = 0; c < 8; c++) ld_data[c*8 +: 8] = pat(r, c);
      tick(1);
    end
    ld_en = 1'b0;
    tick(2);
  endtask

  task automatic t_read();
    logic [7:0] q;
    int e0 = nerr;
    xfer(1, 0, 1, 0, 1, 12);
    chk("R5 output mode", int'(sport_in), 0);
    for (int c = 0; c < 3; c++) begin
      spulse(8'h00, q);
      chk("R5/R12 read word", int'(q), int'(pat(1, c)));
    end
    tick(6);
    chk("R5 no error", nerr - e0, 0);
  endtask

  task automatic t_wrap();
    logic [7:0] q;
    xfer(1, 0, 2, 6, 1, 12);
    spulse(8'h00, q); chk("R4 start col6", int'(q), int'(pat(2, 6)));
    spulse(8'h00, q); chk("R4 col7", int'(q), int'(pat(2, 7)));
    spulse(8'h00, q); chk("R4 wrap col0", int'(q), int'(pat(2, 0)));
    tick(6);
  endtask

  task automatic t_wrdir();
    logic [7:0] q;
    int e0 = nerr;
    xfer(0, 0, 3, 0, 1, 12);
    chk("R9 error", nerr - e0, 1);
    chk("R9 still output", int'(sport_in), 0);
    xfer(1, 0, 3, 0, 1, 12);
    spulse(8'h00, q);
    chk("R9 row unchanged", int'(q), int'(pat(3, 0)));
    tick(6);
  endtask

  task automatic t_pseudo();
    logic [7:0] q;
    int e0;
    xfer(1, 0, 1, 0, 1, 12);
    e0 = nerr;
    xfer(0, 1, 5, 3, 1, 12);
    chk("R3 input mode", int'(sport_in), 1);
    chk("R3 no error", nerr - e0, 0);
    xfer(0, 0, 6, 0, 1, 12);
    xfer(1, 0, 6, 0, 1, 12);
    spulse(8'h00, q);
    chk("R2/R3 register kept", int'(q), int'(pat(1, 0)));
    tick(6);
    xfer(1, 0, 5, 0, 1, 12);
    spulse(8'h00, q);
    chk("R3 row untouched", int'(q), int'(pat(5, 0)));
    tick(6);
  endtask

  task automatic t_shift();
    logic [7:0] q;
    xfer(0, 1, 0, 2, 1, 12);
    for (int i = 0; i < 8; i++) spulse(8'(8'hA0 + i), q);
    xfer(0, 0, 4, 0, 1, 12);
    xfer(1, 0, 4, 2, 1, 12);
    spulse(8'h00, q); chk("R6 col2", int'(q), 8'hA0);
    spulse(8'h00, q); chk("R2 col3", int'(q), 8'hA1);
    tick(6);
  endtask

  task automatic t_lock();
    logic [7:0] q;
    int e0 = nerr;
    xfer(0, 1, 0, 0, 1, 0);
    spulse(8'h99, q);
    tick(12);
    chk("R7 edge after rise refused", nerr - e0, 1);
    spulse(8'h55, q);
    xfer(0, 0, 7, 0, 1, 12);
    xfer(1, 0, 7, 0, 1, 12);
    spulse(8'h00, q);
    chk("R7 refused edge stored nothing", int'(q), 8'h55);
    tick(6);
    e0 = nerr;
    te_n = 1'b0; we_n = 1'b0; se_n = 1'b1; addr = 3'd0; rs_n = 1'b0;
    tick(2);
    cs_n = 1'b0;
    spulse(8'h11, q);
    rs_n = 1'b1; cs_n = 1'b1; te_n = 1'b1; we_n = 1'b1; se_n = 1'b1;
    tick(12);
    chk("R7 edge in row cycle", nerr - e0, 1);
  endtask

  task automatic t_nocas();
    int e0;
    xfer(1, 0, 1, 0, 1, 12);
    e0 = nerr;
    xfer(0, 1, 0, 0, 0, 12);
    chk("R8 error", nerr - e0, 1);
    chk("R8 mode unchanged", int'(sport_in), 0);
  endtask

  task automatic t_gap();
    logic [7:0] q;
    int e0;
    xfer(1, 0, 1, 0, 1, 12);
    spulse(8'h00, q);
    chk("R10 first word", int'(q), int'(pat(1, 0)));
    e0 = nerr;
    xfer(1, 0, 2, 0, 1, 12);
    chk("R10 error", nerr - e0, 1);
    spulse(8'h00, q);
    chk("R10 read dropped", int'(q), int'(pat(1, 1)));
    tick(6);
  endtask

  task automatic t_ignore();
    logic [7:0] q;
    int e0 = nerr;
    te_n = 1'b1; we_n = 1'b0; se_n = 1'b0; addr = 3'd3; rs_n = 1'b0;
    tick(2);
    cs_n = 1'b0;
    tick(2);
    rs_n = 1'b1; cs_n = 1'b1; we_n = 1'b1; se_n = 1'b1;
    tick(12);
    chk("R11 no error", nerr - e0, 0);
    chk("R11 mode kept", int'(sport_in), 0);
    spulse(8'h00, q);
    chk("R11 register kept", int'(q), int'(pat(1, 2)));
    tick(6);
  endtask

  task automatic t_collide();
    logic [7:0] q;
    xfer(0, 1, 0, 0, 1, 12);
    for (int i = 0; i < 8; i++) spulse(8'(8'hC0 + i), q);
    te_n = 1'b0; we_n = 1'b0; se_n = 1'b0; addr = 3'd2; rs_n = 1'b0;
    tick(2);
    addr = 3'd0; cs_n = 1'b0;
    tick(2);
    rs_n = 1'b1; cs_n = 1'b1; te_n = 1'b1; we_n = 1'b1; se_n = 1'b1;
    tick(2);
    ld_en = 1'b1; ld_row = 3'd5; ld_data = {8{8'hEE}};
    tick(1);
    ld_en = 1'b0;
    tick(12);
    xfer(1, 0, 5, 0, 1, 12);
    spulse(8'h00, q);
    chk("R12 load dropped", int'(q), int'(pat(5, 0)));
    tick(6);
    xfer(1, 0, 2, 0, 1, 12);
    spulse(8'h00, q);
    chk("R12/R2 commit won", int'(q), 8'hC0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(4);
    rst = 1'b0;
    t_reset();
    t_load();
    t_read();
    t_wrap();
    t_wrdir();
    t_pseudo();
    t_shift();
    t_lock();
    t_nocas();
    t_gap();
    t_ignore();
    t_collide();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule